// File: doc/BRIEF.md
# Shared-Function GPIO Port Slice

This block is one general-purpose I/O port of configurable width (eight pins by default). Software-visible state is two registers: a direction register, where 1 makes a pin an output, and an output register, which sets the level driven on an output pin or requests a pull-up on an input pin. Pin levels come back through a multi-stage synchronizer for readback. A single write port and a single combinational read port reach all of this state through a two-bit address.

Four pins are shared with on-chip peripherals. These are a serial transceiver (receive data, transmit data and a bit clock), a timer compare channel and a two-input analog comparator. Each shared pin gets an override record. For the pull-up, the direction, the output value and the digital input enable, the record holds an enable and a value. Where the enable is set, the value replaces what the registers would produce.

A parameter mask marks pins that carry a debug test interface. While that interface is enabled, their pull-ups are held on, even during reset. The synchronized values of the receive pin and the clock pin are also routed straight to the peripherals.

Top module: `gpio_alt_port`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the direction and output registers are 0. `pin_oe` and `pin_out` are then all 0, and `pin_pu` is 0 except for the debug pins described in R11.
- R2: A write with `wr_addr` = 1 loads the direction register, and a write with `wr_addr` = 2 loads the output register. A read with `rd_addr` = 1 or 2 returns that register in the same cycle.
- R3: A write with `wr_addr` = 0 inverts each output-register bit whose `wr_data` bit is 1. Output-register bits whose `wr_data` bit is 0 keep their value.
- R4: When a pin has no pull-up override and is not a debug pin with debug enabled, its pull-up is on exactly when its direction bit is 0, its output bit is 1 and `pud` is 0.
- R5: `rd_addr` = 0 returns the pin levels after the synchronizer, ANDed with `pin_ie`. A level applied before clock edge k is visible after edge k+1.
- R6: While `rx_en` is 1, pin 0 is an input (`pin_oe[0]` = 0). Its pull-up then equals output bit 0 AND NOT `pud`. `rx_data_in` always carries synchronized pin 0.
- R7: While `tx_en` is 1, pin 1 is an output, it drives `tx_data`, and its pull-up is off.
- R8: While `sclk_mode` is 1, pin 2 drives `sclk_out`. `sclk_in` always carries synchronized, enable-gated pin 2.
- R9: While `ocmp_en` is 1, pin 3 drives `ocmp_out`.
- R10: `cmp_in0_dis` clears `pin_ie[2]` and `cmp_in1_dis` clears `pin_ie[3]`, and a disabled pin reads as 0. Pins 0 and 1 always have their input enabled.
- R11: While `dbg_en` is 1, every pin whose `DBG_PU_MASK` bit is 1 has its pull-up on, including while reset is asserted.
- R12: A write with `wr_addr` = 3 changes no register, and a read with `rd_addr` = 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 toggle, 1 direction, 2 output, 3 none) |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 2 | Read address (0 pins, 1 direction, 2 output, 3 zero) |
| rd_data | output | WIDTH | Read data |
| pin_in | input | WIDTH | Pad input levels |
| pin_out | output | WIDTH | Pad output levels |
| pin_oe | output | WIDTH | Pad output enables |
| pin_pu | output | WIDTH | Pad pull-up enables |
| pin_ie | output | WIDTH | Pad digital input enables |
| pud | input | 1 | Global pull-up disable |
| dbg_en | input | 1 | Debug interface enabled |
| rx_en | input | 1 | Receiver enable |
| rx_data_in | output | 1 | Synchronized receive data |
| tx_en | input | 1 | Transmitter enable |
| tx_data | input | 1 | Transmit data bit |
| sclk_mode | input | 1 | Serial clock output select |
| sclk_out | input | 1 | Serial clock to drive |
| sclk_in | output | 1 | Synchronized serial clock input |
| ocmp_en | input | 1 | Timer compare output enable |
| ocmp_out | input | 1 | Timer compare output level |
| cmp_in0_dis | input | 1 | Comparator input 0 digital disable (pin 2) |
| cmp_in1_dis | input | 1 | Comparator input 1 digital disable (pin 3) |

## Verification
The bench builds the port with WIDTH = 8 and SYNC_STAGES = 2. It sets DBG_PU_MASK to 8'hB1, which puts a debug pin on the receive pin. That brings the forced debug pull-up into contact with the receiver's pull-up override, which the default mask never exercises. With two synchronizer stages, the readback delay of R5 can be checked edge by edge, alongside random mixes of overrides, register writes and a mid-run reset.

// File: rtl/gpio_alt_pkg.sv
package gpio_alt_pkg;

    typedef enum logic [1:0] {
        PA_PIN  = 2'd0,
        PA_DIR  = 2'd1,
        PA_OUT  = 2'd2,
        PA_RSVD = 2'd3
    } port_addr_e;

    // Per-pin override record: each enable selects its paired value.
    typedef struct packed {
        logic pu_en;
        logic pu_val;
        logic dir_en;
        logic dir_val;
        logic dout_en;
        logic dout_val;
        logic din_en;
        logic din_val;
    } pin_ovr_t;

    localparam pin_ovr_t OVR_NONE = '0;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_alt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic [WIDTH-1:0] pin_val,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] rd_data
);

    port_addr_e wa;
    port_addr_e ra;
    assign wa = port_addr_e'(wr_addr);
    assign ra = port_addr_e'(rd_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else if (wr_en) begin
            case (wa)
                PA_PIN:  out_q <= out_q ^ wr_data;
                PA_DIR:  dir_q <= wr_data;
                PA_OUT:  out_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (ra)
            PA_PIN:  rd_data = pin_val;
            PA_DIR:  rd_data = dir_q;
            PA_OUT:  rd_data = out_q;
            default: rd_data = '0;
        endcase
    end

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa == PA_PIN) |=> (out_q == ($past(out_q) ^ $past(wr_data)))); // R3

    AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa == PA_RSVD) |=> ($stable(dir_q) && $stable(out_q))); // R12

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa == PA_DIR) |=> (dir_q == $past(wr_data))); // R2

endmodule

// File: rtl/gpio_alt_map.sv
module gpio_alt_map
    import gpio_alt_pkg::*;
#(
    parameter int WIDTH = 8   // at least 4: pins 0..3 carry peripheral functions
) (
    input  logic                      pud,
    input  logic                      out0,
    input  logic                      rx_en,
    input  logic                      tx_en,
    input  logic                      tx_data,
    input  logic                      sclk_mode,
    input  logic                      sclk_out,
    input  logic                      ocmp_en,
    input  logic                      ocmp_out,
    input  logic                      cmp_in0_dis,
    input  logic                      cmp_in1_dis,
    output pin_ovr_t [WIDTH-1:0]      ovr
);

    always_comb begin
        for (int i = 0; i < WIDTH; i++) ovr[i] = OVR_NONE;

        // Pin 0: receive data, forced to input, pull-up from its own output bit
        ovr[0].dir_en   = rx_en;
        ovr[0].dir_val  = 1'b0;
        ovr[0].pu_en    = rx_en;
        ovr[0].pu_val   = out0 & ~pud;

        // Pin 1: transmit data, forced to output, no pull-up
        ovr[1].dir_en   = tx_en;
        ovr[1].dir_val  = 1'b1;
        ovr[1].pu_en    = tx_en;
        ovr[1].pu_val   = 1'b0;
        ovr[1].dout_en  = tx_en;
        ovr[1].dout_val = tx_data;

        // Pin 2: serial clock output, comparator input 0
        ovr[2].dout_en  = sclk_mode;
        ovr[2].dout_val = sclk_out;
        ovr[2].din_en   = cmp_in0_dis;
        ovr[2].din_val  = 1'b0;

        // Pin 3: timer compare output, comparator input 1
        ovr[3].dout_en  = ocmp_en;
        ovr[3].dout_val = ocmp_out;
        ovr[3].din_en   = cmp_in1_dis;
        ovr[3].din_val  = 1'b0;
    end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_alt_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] DBG_PU_MASK = WIDTH'(8'hB0)
) (
    input  logic                 pud,
    input  logic                 dbg_en,
    input  logic [WIDTH-1:0]     dir_q,
    input  logic [WIDTH-1:0]     out_q,
    input  pin_ovr_t [WIDTH-1:0] ovr,
    output logic [WIDTH-1:0]     pin_oe,
    output logic [WIDTH-1:0]     pin_out,
    output logic [WIDTH-1:0]     pin_pu,
    output logic [WIDTH-1:0]     pin_ie
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic reg_pu;
        logic ovr_pu;
        assign reg_pu     = ~dir_q[i] & out_q[i] & ~pud;
        assign ovr_pu     = ovr[i].pu_en ? ovr[i].pu_val : reg_pu;
        assign pin_pu[i]  = ovr_pu | (DBG_PU_MASK[i] & dbg_en);
        assign pin_oe[i]  = ovr[i].dir_en  ? ovr[i].dir_val  : dir_q[i];
        assign pin_out[i] = ovr[i].dout_en ? ovr[i].dout_val : out_q[i];
        assign pin_ie[i]  = ovr[i].din_en  ? ovr[i].din_val  : 1'b1;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2   // at least 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] pin_ie,
    output logic [WIDTH-1:0] sync_val
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= pin_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign sync_val = stg[LAST] & pin_ie;

    AST_SYNC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stg[LAST] == $past(stg[LAST-1]))); // R5

    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stg[0] == $past(pin_in))); // R5

endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
    import gpio_alt_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] DBG_PU_MASK = WIDTH'(8'hB0)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu,
    output logic [WIDTH-1:0] pin_ie,
    input  logic             pud,
    input  logic             dbg_en,
    input  logic             rx_en,
    output logic             rx_data_in,
    input  logic             tx_en,
    input  logic             tx_data,
    input  logic             sclk_mode,
    input  logic             sclk_out,
    output logic             sclk_in,
    input  logic             ocmp_en,
    input  logic             ocmp_out,
    input  logic             cmp_in0_dis,
    input  logic             cmp_in1_dis
);

    logic [WIDTH-1:0]     dir_q;
    logic [WIDTH-1:0]     out_q;
    logic [WIDTH-1:0]     sync_val;
    pin_ovr_t [WIDTH-1:0] ovr;

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .pin_val (sync_val),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .rd_data (rd_data)
    );

    gpio_alt_map #(.WIDTH(WIDTH)) u_map (
        .pud         (pud),
        .out0        (out_q[0]),
        .rx_en       (rx_en),
        .tx_en       (tx_en),
        .tx_data     (tx_data),
        .sclk_mode   (sclk_mode),
        .sclk_out    (sclk_out),
        .ocmp_en     (ocmp_en),
        .ocmp_out    (ocmp_out),
        .cmp_in0_dis (cmp_in0_dis),
        .cmp_in1_dis (cmp_in1_dis),
        .ovr         (ovr)
    );

    gpio_pin_mux #(.WIDTH(WIDTH), .DBG_PU_MASK(DBG_PU_MASK)) u_mux (
        .pud     (pud),
        .dbg_en  (dbg_en),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .ovr     (ovr),
        .pin_oe  (pin_oe),
        .pin_out (pin_out),
        .pin_pu  (pin_pu),
        .pin_ie  (pin_ie)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_ie   (pin_ie),
        .sync_val (sync_val)
    );

    assign rx_data_in = sync_val[0];
    assign sclk_in    = sync_val[2];

    AST_RX_PIN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> !pin_oe[0]); // R6

    AST_TX_PIN_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (pin_oe[1] && pin_out[1] == tx_data)); // R7

    AST_CMP_DIS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_in0_dis |-> (!sclk_in && !pin_ie[2])); // R10

    AST_OCMP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ocmp_en |-> (pin_out[3] == ocmp_out)); // R9

    always @(posedge clk) begin
        if (dbg_en) begin
            AST_DBG_PULLUPS: assert ((pin_pu & DBG_PU_MASK) == DBG_PU_MASK); // R11
        end
    end

endmodule

// File: tb/tb_gpio_alt_port.sv
`timescale 1ns/1ps
module tb_gpio_alt_port;

    localparam int         W    = 8;
    localparam logic [7:0] MASK = 8'hB1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [1:0]   wr_addr;
    logic [W-1:0] wr_data;
    logic [1:0]   rd_addr;
    logic [W-1:0] rd_data;
    logic [W-1:0] pin_in;
    logic [W-1:0] pin_out, pin_oe, pin_pu, pin_ie;
    logic pud, dbg_en, rx_en, rx_data_in, tx_en, tx_data;
    logic sclk_mode, sclk_out, sclk_in, ocmp_en, ocmp_out;
    logic cmp_in0_dis, cmp_in1_dis;

    always #2.5 clk = ~clk;

    gpio_alt_port #(.WIDTH(W), .SYNC_STAGES(2), .DBG_PU_MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_ie(pin_ie), .pud(pud), .dbg_en(dbg_en),
        .rx_en(rx_en), .rx_data_in(rx_data_in), .tx_en(tx_en), .tx_data(tx_data),
        .sclk_mode(sclk_mode), .sclk_out(sclk_out), .sclk_in(sclk_in),
        .ocmp_en(ocmp_en), .ocmp_out(ocmp_out),
        .cmp_in0_dis(cmp_in0_dis), .cmp_in1_dis(cmp_in1_dis)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] m_dir, m_out, m_p1, m_p2;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] e_oe();
        logic [7:0] o = m_dir;
        if (rx_en) o[0] = 1'b0;
        if (tx_en) o[1] = 1'b1;
        return o;
    endfunction

    function automatic logic [7:0] e_out();
        logic [7:0] o = m_out;
        if (tx_en)     o[1] = tx_data;
        if (sclk_mode) o[2] = sclk_out;
        if (ocmp_en)   o[3] = ocmp_out;
        return o;
    endfunction

    function automatic logic [7:0] e_pu();
        logic [7:0] o = ~m_dir & m_out & {8{~pud}};
        if (rx_en) o[0] = m_out[0] & ~pud;
        if (tx_en) o[1] = 1'b0;
        if (dbg_en) o = o | MASK;
        return o;
    endfunction

    function automatic logic [7:0] e_ie();
        logic [7:0] o = 8'hFF;
        o[2] = ~cmp_in0_dis;
        o[3] = ~cmp_in1_dis;
        return o;
    endfunction

    function automatic logic [7:0] e_rd();
        case (rd_addr)
            2'd0:    return m_p2 & e_ie();
            2'd1:    return m_dir;
            2'd2:    return m_out;
            default: return 8'h00;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_p1 = '0; m_p2 = '0;
        end else begin
            m_p2 = m_p1;
            m_p1 = pin_in;
            if (wr_en) begin
                case (wr_addr)
                    2'd0:    m_out = m_out ^ wr_data;
                    2'd1:    m_dir = wr_data;
                    2'd2:    m_out = wr_data;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic check_all();
        #1;
        chk("R6 R7 pin_oe", pin_oe, e_oe());
        chk("R9 pin_out", pin_out, e_out());
        chk("R4 pin_pu", pin_pu, e_pu());
        chk("R10 pin_ie", pin_ie, e_ie());
        chk("R5 rd_data", rd_data, e_rd());
        chk("R6 rx_data_in", rx_data_in, m_p2[0]);
        chk("R8 sclk_in", sclk_in, m_p2[2] & ~cmp_in0_dis);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; pin_in = 0;
        pud = 0; dbg_en = 1; rx_en = 0; tx_en = 0; tx_data = 0; sclk_mode = 0;
        sclk_out = 0; ocmp_en = 0; ocmp_out = 0; cmp_in0_dis = 0; cmp_in1_dis = 0;
        m_dir = 0; m_out = 0; m_p1 = 0; m_p2 = 0;
        tick(); tick();
        #1;
        chk("R11 pu in reset", pin_pu, MASK);
        chk("R1 oe in reset", pin_oe, 8'h00);
        chk("R1 out in reset", pin_out, 8'h00);
        dbg_en = 0;
        #1;
        chk("R1 pu in reset", pin_pu, 8'h00);
        rst_n = 1'b1;
        tick();
        check_all();

        wr(2'd2, 8'hF0);
        wr(2'd1, 8'h3C);
        rd_addr = 2'd1; #1; chk("R2 dir read", rd_data, 8'h3C);
        rd_addr = 2'd2; #1; chk("R2 out read", rd_data, 8'hF0);
        chk("R4 pu pattern", pin_pu, 8'hC0);
        pud = 1'b1; #1; chk("R4 pud off", pin_pu, 8'h00);
        pud = 1'b0;

        wr(2'd0, 8'h0F);
        #1; chk("R3 toggle ones", rd_data, 8'hFF);
        wr(2'd0, 8'h00);
        #1; chk("R3 toggle zero", rd_data, 8'hFF);

        wr(2'd3, 8'h5A);
        #1; chk("R12 out kept", rd_data, 8'hFF);
        rd_addr = 2'd1; #1; chk("R12 dir kept", rd_data, 8'h3C);
        rd_addr = 2'd3; #1; chk("R12 rsvd read", rd_data, 8'h00);

        rd_addr = 2'd0; pin_in = 8'hA5;
        tick(); #1; chk("R5 one edge", rd_data, 8'h00);
        tick(); #1; chk("R5 two edges", rd_data, 8'hA5);

        wr(2'd1, 8'hFF);
        rx_en = 1'b1; tx_en = 1'b1; tx_data = 1'b1;
        #1;
        chk("R6 rx input", pin_oe[0], 1'b0);
        chk("R6 rx pull-up", pin_pu[0], 1'b1);
        chk("R7 tx output", {pin_oe[1], pin_out[1], pin_pu[1]}, 3'b110);
        sclk_mode = 1'b1; sclk_out = 1'b0; ocmp_en = 1'b1; ocmp_out = 1'b0;
        #1;
        chk("R8 sclk drive", pin_out[2], 1'b0);
        chk("R9 ocmp drive", pin_out[3], 1'b0);
        cmp_in0_dis = 1'b1; cmp_in1_dis = 1'b1;
        #1;
        chk("R10 ie", pin_ie, 8'hF3);
        chk("R10 read zero", rd_data, 8'hA1);
        check_all();
        tick();

        for (int i = 0; i < 600; i++) begin
            if (i == 300) begin
                rst_n = 1'b0; dbg_en = 1'b1;
                m_dir = '0; m_out = '0; m_p1 = '0; m_p2 = '0;
                #1; chk("R11 pu mid reset", pin_pu & MASK, MASK);
                chk("R1 oe mid reset", pin_oe & 8'hFE, {6'h00, tx_en, 1'b0});
                tick();
                rst_n = 1'b1;
            end
            wr_en       = ($urandom % 10) < 3;
            wr_addr     = 2'($urandom);
            wr_data     = 8'($urandom);
            rd_addr     = 2'($urandom);
            pin_in      = 8'($urandom);
            pud         = ($urandom % 5) == 0;
            dbg_en      = ($urandom % 4) == 0;
            rx_en       = 1'($urandom);
            tx_en       = 1'($urandom);
            tx_data     = 1'($urandom);
            sclk_mode   = 1'($urandom);
            sclk_out    = 1'($urandom);
            ocmp_en     = 1'($urandom);
            ocmp_out    = 1'($urandom);
            cmp_in0_dis = ($urandom % 3) == 0;
            cmp_in1_dis = ($urandom % 3) == 0;
            check_all();
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule